// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. It follows the standard 16-state test access port state machine, clocked by the test clock and steered by the mode-select input, and places one of three data paths between the serial input and the serial output: a 32-bit identification register, a 1-bit bypass register, or an external boundary chain. The chain is reached through a small strobe interface (select, capture, shift, update, serial in, serial out), so the boundary cells can live elsewhere on the chip.

A 3-bit instruction register chooses the path. Opcode 001 picks the identification word. Opcodes 000, 010 and 101 pick the boundary chain. The four remaining codes (011, 100, 110, 111) pick the bypass bit. The serial output changes on the falling test-clock edge and is enabled only while a register is being shifted. An active-low asynchronous reset, or five clocks with mode-select high, returns the port to its reset state with the identification opcode loaded.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: While `trst_n` is low, the port is forced to Test-Logic-Reset at once, without waiting for a clock. In that state `tdo_oe` is 0 and the instruction is 001 (identification), so `bnd_sel` is 0.
- R2: Five consecutive rising `tck` edges with `tms` = 1 bring the state machine to Test-Logic-Reset from any state.
- R3: In Capture-IR the instruction shift path loads 001. It is shifted out least significant bit first, and `tdi` enters at the most significant end.
- R4: Opcode 001 selects a 32-bit identification register that loads 0x073670CD in Capture-DR and shifts it out LSB first.
- R5: Opcodes 011, 100, 110 and 111 select a 1-bit bypass register. It loads 0 in Capture-DR, so shifted data reaches `tdo` one clock late, preceded by a 0.
- R6: Opcodes 000, 010 and 101 assert `bnd_sel`. With `bnd_sel` high, `bnd_capture`, `bnd_shift` and `bnd_update` are high exactly in Capture-DR, Shift-DR and Update-DR. `bnd_si` follows `tdi`, and `tdo` shifts out `bnd_so`. With `bnd_sel` low, all three strobes stay 0.
- R7: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is 1 only during Shift-IR and Shift-DR.
- R8: A newly shifted instruction changes the data-path selection only on the falling `tck` edge in Update-IR. Shifting alone leaves the selection unchanged.
- R9: Entering Test-Logic-Reset through `tms` reloads the instruction with 001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` (high only while shifting) |
| bnd_sel | output | 1 | Boundary chain is the selected data path |
| bnd_capture | output | 1 | Boundary chain capture strobe |
| bnd_shift | output | 1 | Boundary chain shift strobe |
| bnd_update | output | 1 | Boundary chain update strobe |
| bnd_si | output | 1 | Serial data toward the boundary chain |
| bnd_so | input | 1 | Serial data returning from the boundary chain |

## Verification
State, capture and shift results become visible at the rising `tck` edge on which `tms` and `tdi` are sampled. `tdo`, `tdo_oe` and any new instruction selection appear half a clock later, on the following falling edge. The boundary strobes follow the state register with no added delay. The bench changes inputs just after each falling edge and compares every output with its model 0.5 ns after that falling edge, where all of these results are settled. The only exception is the asynchronous reset check, which samples `tdo_oe` and the strobes between edges, half a nanosecond after `trst_n` falls.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_IDENT   = 3'b001;
  localparam logic [IR_W-1:0] OP_IRCAPT  = 3'b001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SEL, ST_DR_CAP, ST_DR_SHF, ST_DR_EX1, ST_DR_PAU, ST_DR_EX2, ST_DR_UPD,
    ST_IR_SEL, ST_IR_CAP, ST_IR_SHF, ST_IR_EX1, ST_IR_PAU, ST_IR_EX2, ST_IR_UPD
  } tap_state_t;

  typedef enum logic [1:0] {
    PATH_BND,
    PATH_ID,
    PATH_BYP
  } dr_path_t;

  function automatic dr_path_t decode_op(input logic [IR_W-1:0] op);
    case (op)
      3'b001:                 return PATH_ID;
      3'b000, 3'b010, 3'b101: return PATH_BND;
      default:                return PATH_BYP;
    endcase
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_t state
);

  localparam int ONES_TO_RESET = 5;
  localparam int CNT_W = $clog2(ONES_TO_RESET + 1);

  tap_state_t nxt;

  always_comb begin
    case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_DR_SEL : ST_IDLE;
      ST_DR_SEL: nxt = tms ? ST_IR_SEL : ST_DR_CAP;
      ST_DR_CAP: nxt = tms ? ST_DR_EX1 : ST_DR_SHF;
      ST_DR_SHF: nxt = tms ? ST_DR_EX1 : ST_DR_SHF;
      ST_DR_EX1: nxt = tms ? ST_DR_UPD : ST_DR_PAU;
      ST_DR_PAU: nxt = tms ? ST_DR_EX2 : ST_DR_PAU;
      ST_DR_EX2: nxt = tms ? ST_DR_UPD : ST_DR_SHF;
      ST_DR_UPD: nxt = tms ? ST_DR_SEL : ST_IDLE;
      ST_IR_SEL: nxt = tms ? ST_RESET  : ST_IR_CAP;
      ST_IR_CAP: nxt = tms ? ST_IR_EX1 : ST_IR_SHF;
      ST_IR_SHF: nxt = tms ? ST_IR_EX1 : ST_IR_SHF;
      ST_IR_EX1: nxt = tms ? ST_IR_UPD : ST_IR_PAU;
      ST_IR_PAU: nxt = tms ? ST_IR_EX2 : ST_IR_PAU;
      ST_IR_EX2: nxt = tms ? ST_IR_UPD : ST_IR_SHF;
      ST_IR_UPD: nxt = tms ? ST_DR_SEL : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= nxt;
  end

  // Checker-side run length of tms ones, used only by the assertion below.
  logic [CNT_W-1:0] ones_run;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                                   ones_run <= '0;
    else if (!tms)                                 ones_run <= '0;
    else if (ones_run != CNT_W'(ONES_TO_RESET))    ones_run <= ones_run + 1'b1;
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_run == CNT_W'(ONES_TO_RESET)) |-> (state == ST_RESET)); // R2

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import jtag_tap_pkg::*;
#(
  parameter int               W        = IR_W,
  parameter logic [W-1:0]     CAPT_PAT = OP_IRCAPT,
  parameter logic [W-1:0]     RST_OP   = OP_IDENT
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         tdi,
  input  tap_state_t   state,
  output logic         sr_lsb,
  output logic [W-1:0] op_q
);

  logic [W-1:0] sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr <= CAPT_PAT;
    end else begin
      case (state)
        ST_IR_CAP: sr <= CAPT_PAT;
        ST_IR_SHF: sr <= {tdi, sr[W-1:1]};
        default:   sr <= sr;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                 op_q <= RST_OP;
    else if (state == ST_RESET)  op_q <= RST_OP;
    else if (state == ST_IR_UPD) op_q <= sr;
  end

  assign sr_lsb = sr[0];

  AST_IR_CAPTURE_PATTERN: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_IR_CAP) |=> (sr == CAPT_PAT)); // R3

  AST_IR_CHANGE_AT_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(op_q) |-> (state == ST_IR_UPD || state == ST_RESET)); // R8

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import jtag_tap_pkg::*;
#(
  parameter int          ID_W    = 32,
  parameter logic [ID_W-1:0] ID_WORD = 32'h073670CD
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tdi,
  input  tap_state_t state,
  input  dr_path_t   path,
  input  logic       bnd_so,
  output logic       dr_lsb
);

  logic [ID_W-1:0] id_sr;
  logic            byp;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      id_sr <= ID_WORD;
      byp   <= 1'b0;
    end else begin
      if (state == ST_DR_CAP) begin
        if (path == PATH_ID)  id_sr <= ID_WORD;
        if (path == PATH_BYP) byp   <= 1'b0;
      end else if (state == ST_DR_SHF) begin
        if (path == PATH_ID)  id_sr <= {tdi, id_sr[ID_W-1:1]};
        if (path == PATH_BYP) byp   <= tdi;
      end
    end
  end

  always_comb begin
    case (path)
      PATH_ID:  dr_lsb = id_sr[0];
      PATH_BYP: dr_lsb = byp;
      default:  dr_lsb = bnd_so;
    endcase
  end

  AST_BYP_CAPTURES_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_DR_CAP && path == PATH_BYP) |=> (byp == 1'b0)); // R5

  AST_ID_CAPTURE_WORD: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_DR_CAP && path == PATH_ID) |=> (id_sr == ID_WORD)); // R4

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import jtag_tap_pkg::*;
#(
  parameter int              ID_W    = 32,
  parameter logic [ID_W-1:0] ID_WORD = 32'h073670CD
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_oe,
  output logic bnd_sel,
  output logic bnd_capture,
  output logic bnd_shift,
  output logic bnd_update,
  output logic bnd_si,
  input  logic bnd_so
);

  tap_state_t      state;
  logic [IR_W-1:0] op_q;
  logic            ir_lsb;
  logic            dr_lsb;
  dr_path_t        path;

  tap_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (state)
  );

  tap_ir #(
    .W        (IR_W),
    .CAPT_PAT (OP_IRCAPT),
    .RST_OP   (OP_IDENT)
  ) u_ir (
    .tck    (tck),
    .trst_n (trst_n),
    .tdi    (tdi),
    .state  (state),
    .sr_lsb (ir_lsb),
    .op_q   (op_q)
  );

  assign path = decode_op(op_q);

  tap_dr #(
    .ID_W    (ID_W),
    .ID_WORD (ID_WORD)
  ) u_dr (
    .tck    (tck),
    .trst_n (trst_n),
    .tdi    (tdi),
    .state  (state),
    .path   (path),
    .bnd_so (bnd_so),
    .dr_lsb (dr_lsb)
  );

  assign bnd_sel     = (path == PATH_BND);
  assign bnd_capture = bnd_sel && (state == ST_DR_CAP);
  assign bnd_shift   = bnd_sel && (state == ST_DR_SHF);
  assign bnd_update  = bnd_sel && (state == ST_DR_UPD);
  assign bnd_si      = tdi;

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state == ST_IR_SHF) || (state == ST_DR_SHF);
      if (state == ST_IR_SHF)      tdo <= ir_lsb;
      else if (state == ST_DR_SHF) tdo <= dr_lsb;
    end
  end

  AST_OE_ONLY_SHIFTING: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == ST_IR_SHF || state == ST_DR_SHF)); // R7

  AST_STROBES_EXCLUSIVE: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({bnd_capture, bnd_shift, bnd_update}) && (!bnd_sel -> !(bnd_capture || bnd_shift || bnd_update))); // R6

endmodule

// File: tb/sim_jtag_tap_ctrl.sv
`timescale 1ns/100ps
module sim_jtag_tap_ctrl;

  localparam logic [31:0] ID_EXP = 32'h073670CD;
  localparam logic [7:0]  CHAIN_CAPT = 8'hA5;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdo_oe, bnd_sel, bnd_capture, bnd_shift, bnd_update, bnd_si, bnd_so;

  always #2 tck = ~tck;

  jtag_tap_ctrl u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_oe(tdo_oe),
    .bnd_sel(bnd_sel), .bnd_capture(bnd_capture), .bnd_shift(bnd_shift),
    .bnd_update(bnd_update), .bnd_si(bnd_si), .bnd_so(bnd_so)
  );

  // External 8-bit boundary chain driven by the strobes, latched mid low phase.
  logic [7:0] ext = 8'h00;
  logic c_l = 1'b0, s_l = 1'b0, u_l = 1'b0, si_l = 1'b0;
  int   upd_cnt = 0;
  always @(negedge tck) begin
    #1;
    c_l = bnd_capture; s_l = bnd_shift; u_l = bnd_update; si_l = bnd_si;
  end
  always @(posedge tck) begin
    if (c_l)      ext <= CHAIN_CAPT;
    else if (s_l) ext <= {si_l, ext[7:1]};
    if (u_l) upd_cnt++;
  end
  assign bnd_so = ext[0];

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  localparam int M_TLR = 0,  M_RTI = 1,  M_SDR = 2,  M_CDR = 3,  M_HDR = 4,  M_E1D = 5,
                 M_PDR = 6,  M_E2D = 7,  M_UDR = 8,  M_SIR = 9,  M_CIR = 10, M_HIR = 11,
                 M_E1I = 12, M_PIR = 13, M_E2I = 14, M_UIR = 15;
  int          m_st = M_TLR;
  int          m_ir = 1;
  logic [2:0]  m_irsr = 3'b001;
  logic [31:0] m_id = ID_EXP;
  logic        m_byp = 1'b0;
  logic [7:0]  m_chain = 8'h00;
  logic        m_tdo = 1'b0;
  logic        m_oe = 1'b0;

  function automatic int m_path(input int ir);
    if (ir == 1) return 1;                            // identification
    if (ir == 0 || ir == 2 || ir == 5) return 0;      // boundary
    return 2;                                         // bypass
  endfunction

  function automatic int m_next(input int s, input bit m);
    case (s)
      M_TLR: return m ? M_TLR : M_RTI;
      M_RTI: return m ? M_SDR : M_RTI;
      M_SDR: return m ? M_SIR : M_CDR;
      M_CDR: return m ? M_E1D : M_HDR;
      M_HDR: return m ? M_E1D : M_HDR;
      M_E1D: return m ? M_UDR : M_PDR;
      M_PDR: return m ? M_E2D : M_PDR;
      M_E2D: return m ? M_UDR : M_HDR;
      M_UDR: return m ? M_SDR : M_RTI;
      M_SIR: return m ? M_TLR : M_CIR;
      M_CIR: return m ? M_E1I : M_HIR;
      M_HIR: return m ? M_E1I : M_HIR;
      M_E1I: return m ? M_UIR : M_PIR;
      M_PIR: return m ? M_E2I : M_PIR;
      M_E2I: return m ? M_UIR : M_HIR;
      default: return m ? M_SDR : M_RTI;
    endcase
  endfunction

  task automatic model_reset();
    m_st = M_TLR; m_ir = 1; m_irsr = 3'b001; m_id = ID_EXP; m_byp = 1'b0; m_oe = 1'b0;
  endtask

  task automatic tick(input bit m, input bit d);
    int p;
    tms = m; tdi = d;
    @(posedge tck);
    p = m_path(m_ir);
    if (m_st == M_CIR) m_irsr = 3'b001;
    if (m_st == M_HIR) m_irsr = {d, m_irsr[2:1]};
    if (m_st == M_CDR) begin
      if (p == 1) m_id = ID_EXP;
      else if (p == 2) m_byp = 1'b0;
      else m_chain = CHAIN_CAPT;
    end
    if (m_st == M_HDR) begin
      if (p == 1) m_id = {d, m_id[31:1]};
      else if (p == 2) m_byp = d;
      else m_chain = {d, m_chain[7:1]};
    end
    m_st = m_next(m_st, m);
    @(negedge tck);
    if (m_st == M_UIR) m_ir = int'(m_irsr);
    if (m_st == M_TLR) m_ir = 1;
    m_oe = (m_st == M_HIR) || (m_st == M_HDR);
    p = m_path(m_ir);
    if (m_st == M_HIR) m_tdo = m_irsr[0];
    if (m_st == M_HDR) m_tdo = (p == 1) ? m_id[0] : (p == 2) ? m_byp : m_chain[0];
    #0.5;
    chk(tdo_oe === m_oe, "R7 tdo_oe", 32'(tdo_oe), 32'(m_oe));
    if (m_oe) chk(tdo === m_tdo, "R7 tdo", 32'(tdo), 32'(m_tdo));
    chk(bnd_sel === (p == 0), "R8 bnd_sel", 32'(bnd_sel), 32'(p == 0));
    chk({bnd_capture, bnd_shift, bnd_update} ===
        {(p == 0) && (m_st == M_CDR), (p == 0) && (m_st == M_HDR), (p == 0) && (m_st == M_UDR)},
        "R6 strobes", 32'({bnd_capture, bnd_shift, bnd_update}),
        32'({(p == 0) && (m_st == M_CDR), (p == 0) && (m_st == M_HDR), (p == 0) && (m_st == M_UDR)}));
    chk(bnd_si === tdi, "R6 bnd_si", 32'(bnd_si), 32'(tdi));
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tick(i == n - 1, din[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scan_ir(input logic [2:0] op, output logic [2:0] dout);
    dout = '0;
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 3; i++) begin
      dout[i] = tdo;
      tick(i == 2, op[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  initial begin
    #(4ns * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [2:0]  irv;
    int          u0cnt;
    repeat (2) @(negedge tck);
    #0.5;
    chk(tdo_oe === 1'b0, "R1 reset oe", 32'(tdo_oe), 0);
    chk(bnd_sel === 1'b0, "R1 reset sel", 32'(bnd_sel), 0);
    trst_n = 1'b1;
    tick(0, 0);

    // R4: identification word straight after reset
    scan_dr(32, 32'hFFFF_FFFF, d);
    chk(d === ID_EXP, "R4 id after reset", d, ID_EXP);

    // R3 and R5: every bypass opcode
    for (int k = 0; k < 4; k++) begin
      logic [2:0] op;
      logic [7:0] pat;
      op  = (k == 0) ? 3'b011 : (k == 1) ? 3'b100 : (k == 2) ? 3'b110 : 3'b111;
      pat = 8'hB2 ^ 8'(k * 37);
      scan_ir(op, irv);
      chk(irv === 3'b001, "R3 ir capture", 32'(irv), 1);
      scan_dr(8, 32'(pat), d);
      chk(d[7:0] === {pat[6:0], 1'b0}, "R5 bypass", d, 32'({pat[6:0], 1'b0}));
    end

    // R6: boundary opcodes
    for (int k = 0; k < 3; k++) begin
      logic [2:0] op;
      logic [7:0] pat;
      op  = (k == 0) ? 3'b000 : (k == 1) ? 3'b010 : 3'b101;
      pat = 8'h3C + 8'(k * 17);
      scan_ir(op, irv);
      chk(bnd_sel === 1'b1, "R6 bnd_sel", 32'(bnd_sel), 1);
      u0cnt = upd_cnt;
      scan_dr(16, {16'h0, pat, 8'h00}, d);
      chk(d[15:0] === {8'h00, CHAIN_CAPT}, "R6 chain out", d, 32'({8'h00, CHAIN_CAPT}));
      chk(ext === pat, "R6 chain in", 32'(ext), 32'(pat));
      chk(upd_cnt == u0cnt + 1, "R6 update pulse", upd_cnt, u0cnt + 1);
    end

    // R8: boundary stays selected while identification opcode is shifted, until update
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    tick(0, 1); tick(0, 0);
    chk(bnd_sel === 1'b1, "R8 sel held in shift", 32'(bnd_sel), 1);
    tick(1, 0);
    chk(bnd_sel === 1'b1, "R8 sel held in exit", 32'(bnd_sel), 1);
    tick(1, 0);
    chk(bnd_sel === 1'b0, "R8 sel after update", 32'(bnd_sel), 0);
    tick(0, 0);
    scan_dr(32, 32'h0, d);
    chk(d === ID_EXP, "R4 id reselected", d, ID_EXP);

    // R2 and R9: five ones from Shift-DR under bypass
    scan_ir(3'b111, irv);
    tick(1, 0); tick(0, 0); tick(0, 0);
    repeat (5) tick(1, 0);
    tick(0, 0);
    scan_dr(32, 32'h0, d);
    chk(d === ID_EXP, "R2 R9 tms reset id", d, ID_EXP);

    // R1: asynchronous reset in the middle of a boundary shift
    scan_ir(3'b000, irv);
    tick(1, 0); tick(0, 0); tick(0, 0);
    chk(tdo_oe === 1'b1, "R7 oe in shift", 32'(tdo_oe), 1);
    trst_n = 1'b0;
    #0.5;
    chk(tdo_oe === 1'b0, "R1 async oe", 32'(tdo_oe), 0);
    chk(bnd_sel === 1'b0, "R1 async sel", 32'(bnd_sel), 0);
    chk(bnd_shift === 1'b0, "R1 async shift", 32'(bnd_shift), 0);
    #0.5;
    trst_n = 1'b1;
    model_reset();
    tick(0, 0);
    scan_dr(32, 32'h0, d);
    chk(d === ID_EXP, "R1 id after async reset", d, ID_EXP);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule